// File: doc/BRIEF.md
# TPM SPI Transaction Framer

This block is an SPI master that performs one register access to a TPM-style SPI device per request. The request carries a direction, a byte count and a 24-bit register address. The framer lowers chip select and sends a four-byte header that encodes the request. It then clocks single idle bytes until the device marks one with its ready bit. After that it moves the data bytes and raises chip select again.

Write data comes in through a byte stream with a valid/ready handshake, and read data goes out as a byte stream with a valid strobe. The bus runs in SPI mode 0, with a half-period set by a parameter. A programmable limit on the number of wait-state bytes makes the framer abandon an access to a device that never becomes ready. Requests that are empty or too long are refused before the bus is touched.

Top module: `tpm_spi_framer`

## Requirements
- R1: The first header byte carries 1 in bit 7 for a read and 0 for a write, a constant 1 in bit 6, and the byte count minus one in bits 5:0.
- R2: A request with a count of 0 or above MAX_BYTES (at most 64) sets `err_len`, leaves `cs_n` high with no SCLK activity, and gives no `done`.
- R3: Header bytes two to four carry the register address, bits 23:16 first, then 15:8, then 7:0.
- R4: `cs_n` goes low before the first SCLK rise and stays low through the header, the wait-state bytes and the data phase. SCLK never rises while `cs_n` is high, and no byte is clocked beyond the frame.
- R5: After the fourth header byte the framer always clocks at least one wait-state byte with MOSI held at 0, and it repeats until a received byte has bit 0 set. Only bit 0 is examined, and the byte received during the header is ignored.
- R6: In a read, each data byte is taken from MISO MSB first and presented on `rd_data` with a one-cycle `rd_valid`, in bus order. MOSI is 0 during these bytes.
- R7: In a write, each data byte is taken when `wr_valid` and `wr_ready` are both high, and it is shifted out on MOSI MSB first, in order.
- R8: If `poll_limit` wait-state bytes in a row come back not ready (a limit of 0 acts as 1), the framer sets `err_timeout`, skips the data phase and releases `cs_n`. A ready bit on the limit-th byte still counts as success.
- R9: `done` pulses for one cycle in the cycle where `cs_n` returns high. `busy` is high from the cycle after an accepted start until that cycle, and it is low otherwise. Both error flags clear when a request is accepted.
- R10: SCLK idles low. MISO is sampled on the rising edge, and MOSI changes only while SCLK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_len | input | LEN_W | Data byte count |
| req_addr | input | 24 | Register address |
| poll_limit | input | POLL_W | Maximum number of wait-state bytes |
| wr_data | input | 8 | Write byte stream data |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Framer takes the write byte this cycle |
| rd_data | output | 8 | Read byte stream data |
| rd_valid | output | 1 | Read byte strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished, chip select released |
| err_len | output | 1 | Last request refused for its length |
| err_timeout | output | 1 | Last access abandoned for lack of readiness |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
Two decisions can fall on the same wait-state byte: the readiness test and the expiry of the poll limit. The bench provokes this with a device that reports ready on exactly the limit-th wait-state byte, so the two conditions arrive together. It then judges from the bus and the flags that readiness wins: the data bytes are clocked and `err_timeout` stays low. A companion case stops one byte short of readiness and must produce the timeout with no data phase.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

   localparam int ADDR_W    = 24;
   localparam int HDR_BYTES = 4;
   localparam int FRAME_MAX = 64;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_HDR,
      ST_POLL,
      ST_DLOAD,
      ST_DXFER,
      ST_HOLD
   } tsf_state_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_HDR,
      PH_POLL,
      PH_DATA
   } tsf_phase_e;

   // Header byte selector: byte 0 is the command, bytes 1..3 the address, MSB first.
   function automatic logic [7:0] tsf_hdr_byte(input logic              rd,
                                               input logic [5:0]        cnt_m1,
                                               input logic [ADDR_W-1:0] addr,
                                               input logic [1:0]        sel);
      case (sel)
         2'd0:    tsf_hdr_byte = {rd, 1'b1, cnt_m1};
         2'd1:    tsf_hdr_byte = addr[23:16];
         2'd2:    tsf_hdr_byte = addr[15:8];
         default: tsf_hdr_byte = addr[7:0];
      endcase
   endfunction

endpackage

// File: rtl/tsf_shifter.sv
module tsf_shifter #(
   parameter int CLK_DIV   = 4,
   parameter bit SYNC_MISO = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic [7:0] rx_byte,
   output logic       done
);

   localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic          miso_s;
   logic [DW-1:0] div_q;
   logic [2:0]    bit_q;
   logic [7:0]    tx_q;
   logic [7:0]    rx_q;
   logic          sclk_q;
   logic          act_q;
   logic          done_q;
   logic          tick;

   generate
      if (SYNC_MISO) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], miso};
         end
         assign miso_s = sync_q[1];
      end else begin : g_direct
         assign miso_s = miso;
      end
   endgenerate

   assign tick = (div_q == DW'(CLK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bit_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         sclk_q <= 1'b0;
         act_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!act_q) begin
            if (start) begin
               act_q  <= 1'b1;
               tx_q   <= tx_byte;
               bit_q  <= '0;
               div_q  <= '0;
               sclk_q <= 1'b0;
            end
         end else if (!tick) begin
            div_q <= div_q + 1'b1;
         end else begin
            div_q <= '0;
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_q   <= {rx_q[6:0], miso_s};
            end else begin
               sclk_q <= 1'b0;
               if (bit_q == 3'd7) begin
                  act_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  tx_q  <= {tx_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign sclk    = sclk_q;
   assign mosi    = act_q & tx_q[7];
   assign rx_byte = rx_q;
   assign done    = done_q;

   AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_q && $past(sclk_q)) |-> $stable(mosi)); // R10

endmodule

// File: rtl/tsf_seq.sv
module tsf_seq
   import tsf_pkg::*;
#(
   parameter int MAX_BYTES = 64,
   parameter int LEN_W     = 7,
   parameter int POLL_W    = 16,
   parameter int CLK_DIV   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_read,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [POLL_W-1:0] poll_limit,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              sh_start,
   output logic [7:0]        sh_tx,
   input  logic              sh_done,
   input  logic [7:0]        sh_rx,
   output logic              cs_n,
   output logic              busy,
   output logic              done,
   output logic              err_len,
   output logic              err_timeout,
   output tsf_phase_e        phase
);

   localparam int GW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   tsf_state_e        state;
   logic              rd_q;
   logic [LEN_W-1:0]  len_q;
   logic [ADDR_W-1:0] addr_q;
   logic [POLL_W-1:0] lim_q;
   logic [LEN_W-1:0]  idx_q;
   logic [POLL_W-1:0] poll_q;
   logic [GW-1:0]     gap_q;
   logic              cs_q;
   logic              done_q;
   logic              errl_q;
   logic              errt_q;
   logic              shs_q;
   logic [7:0]        shtx_q;
   logic              rdv_q;
   logic [7:0]        rdd_q;

   logic              len_ok;
   logic              gap_last;
   logic              poll_spent;
   logic [5:0]        cnt_m1;

   assign len_ok     = (req_len != '0) && (req_len <= LEN_W'(MAX_BYTES));
   assign gap_last   = (gap_q == GW'(CLK_DIV - 1));
   assign poll_spent = (({1'b0, poll_q} + 1'b1) >= {1'b0, lim_q});
   assign cnt_m1     = 6'(len_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         rd_q   <= 1'b0;
         len_q  <= '0;
         addr_q <= '0;
         lim_q  <= '0;
         idx_q  <= '0;
         poll_q <= '0;
         gap_q  <= '0;
         cs_q   <= 1'b1;
         done_q <= 1'b0;
         errl_q <= 1'b0;
         errt_q <= 1'b0;
         shs_q  <= 1'b0;
         shtx_q <= '0;
         rdv_q  <= 1'b0;
         rdd_q  <= '0;
      end else begin
         shs_q  <= 1'b0;
         done_q <= 1'b0;
         rdv_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (len_ok) begin
                     rd_q   <= req_read;
                     len_q  <= req_len;
                     addr_q <= req_addr;
                     lim_q  <= poll_limit;
                     errl_q <= 1'b0;
                     errt_q <= 1'b0;
                     cs_q   <= 1'b0;
                     gap_q  <= '0;
                     state  <= ST_SETUP;
                  end else begin
                     errl_q <= 1'b1;
                  end
               end
            end
            ST_SETUP: begin
               if (gap_last) begin
                  idx_q  <= '0;
                  shs_q  <= 1'b1;
                  shtx_q <= tsf_hdr_byte(rd_q, cnt_m1, addr_q, 2'd0);
                  state  <= ST_HDR;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            ST_HDR: begin
               if (sh_done) begin
                  shs_q <= 1'b1;
                  if (idx_q == LEN_W'(HDR_BYTES - 1)) begin
                     poll_q <= '0;
                     shtx_q <= 8'h00;
                     state  <= ST_POLL;
                  end else begin
                     idx_q  <= idx_q + 1'b1;
                     shtx_q <= tsf_hdr_byte(rd_q, cnt_m1, addr_q, idx_q[1:0] + 2'd1);
                  end
               end
            end
            ST_POLL: begin
               if (sh_done) begin
                  if (sh_rx[0]) begin
                     idx_q <= '0;
                     state <= ST_DLOAD;
                  end else if (poll_spent) begin
                     errt_q <= 1'b1;
                     gap_q  <= '0;
                     state  <= ST_HOLD;
                  end else begin
                     poll_q <= poll_q + 1'b1;
                     shs_q  <= 1'b1;
                     shtx_q <= 8'h00;
                  end
               end
            end
            ST_DLOAD: begin
               if (rd_q) begin
                  shs_q  <= 1'b1;
                  shtx_q <= 8'h00;
                  state  <= ST_DXFER;
               end else if (wr_valid) begin
                  shs_q  <= 1'b1;
                  shtx_q <= wr_data;
                  state  <= ST_DXFER;
               end
            end
            ST_DXFER: begin
               if (sh_done) begin
                  if (rd_q) begin
                     rdv_q <= 1'b1;
                     rdd_q <= sh_rx;
                  end
                  if (idx_q == len_q - 1'b1) begin
                     gap_q <= '0;
                     state <= ST_HOLD;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     state <= ST_DLOAD;
                  end
               end
            end
            ST_HOLD: begin
               if (gap_last) begin
                  cs_q   <= 1'b1;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_HDR:             phase = PH_HDR;
         ST_POLL:            phase = PH_POLL;
         ST_DLOAD, ST_DXFER: phase = PH_DATA;
         default:            phase = PH_IDLE;
      endcase
   end

   assign wr_ready    = (state == ST_DLOAD) && !rd_q;
   assign rd_data     = rdd_q;
   assign rd_valid    = rdv_q;
   assign sh_start    = shs_q;
   assign sh_tx       = shtx_q;
   assign cs_n        = cs_q;
   assign busy        = (state != ST_IDLE);
   assign done        = done_q;
   assign err_len     = errl_q;
   assign err_timeout = errt_q;

   AST_REFUSED_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(errl_q) |-> (cs_n && !busy)); // R2
   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && cs_n)); // R9
   AST_TIMEOUT_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(errt_q) |-> ($past(phase) == PH_POLL)); // R8

endmodule

// File: rtl/tpm_spi_framer.sv
module tpm_spi_framer
   import tsf_pkg::*;
#(
   parameter int MAX_BYTES = 64,
   parameter int LEN_W     = $clog2(MAX_BYTES + 1),
   parameter int POLL_W    = 16,
   parameter int CLK_DIV   = 4,
   parameter bit SYNC_MISO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_read,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [23:0]       req_addr,
   input  logic [POLL_W-1:0] poll_limit,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              done,
   output logic              err_len,
   output logic              err_timeout,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);

   generate
      if (MAX_BYTES < 1 || MAX_BYTES > FRAME_MAX) begin : g_bad_max
         $error("MAX_BYTES must lie in 1..64");
      end
      if (LEN_W < $clog2(MAX_BYTES + 1)) begin : g_bad_lenw
         $error("LEN_W too narrow for MAX_BYTES");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (SYNC_MISO && CLK_DIV < 3) begin : g_bad_sync
         $error("synchronised MISO needs CLK_DIV of 3 or more");
      end
      if (POLL_W < 1) begin : g_bad_poll
         $error("POLL_W must be at least 1");
      end
   endgenerate

   logic       sh_start;
   logic [7:0] sh_tx;
   logic       sh_done;
   logic [7:0] sh_rx;
   tsf_phase_e phase;

   tsf_seq #(
      .MAX_BYTES (MAX_BYTES),
      .LEN_W     (LEN_W),
      .POLL_W    (POLL_W),
      .CLK_DIV   (CLK_DIV)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .req_read    (req_read),
      .req_len     (req_len),
      .req_addr    (req_addr),
      .poll_limit  (poll_limit),
      .wr_data     (wr_data),
      .wr_valid    (wr_valid),
      .wr_ready    (wr_ready),
      .rd_data     (rd_data),
      .rd_valid    (rd_valid),
      .sh_start    (sh_start),
      .sh_tx       (sh_tx),
      .sh_done     (sh_done),
      .sh_rx       (sh_rx),
      .cs_n        (cs_n),
      .busy        (busy),
      .done        (done),
      .err_len     (err_len),
      .err_timeout (err_timeout),
      .phase       (phase)
   );

   tsf_shifter #(
      .CLK_DIV   (CLK_DIV),
      .SYNC_MISO (SYNC_MISO)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sh_start),
      .tx_byte (sh_tx),
      .miso    (miso),
      .sclk    (sclk),
      .mosi    (mosi),
      .rx_byte (sh_rx),
      .done    (sh_done)
   );

   AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n); // R4
   AST_POLL_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_POLL) |-> !mosi); // R5
   AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> done); // R9

endmodule

// File: tb/tpm_spi_framer_tb_top.sv
module tpm_spi_framer_tb_top;

   localparam int LW = 7;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          req_read = 1'b0;
   logic [LW-1:0] req_len = '0;
   logic [23:0]   req_addr = '0;
   logic [PW-1:0] poll_limit = '0;
   logic [7:0]    wr_data = '0;
   logic          wr_valid = 1'b0;
   logic          miso = 1'b0;
   wire           wr_ready, rd_valid, busy, done, err_len, err_timeout, sclk, cs_n, mosi;
   wire  [7:0]    rd_data;

   always #10 clk = ~clk;

   tpm_spi_framer dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .req_read(req_read), .req_len(req_len),
      .req_addr(req_addr), .poll_limit(poll_limit), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
      .err_len(err_len), .err_timeout(err_timeout), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso));

   int total = 0;
   int bad = 0;

   typedef struct {
      logic [7:0] v;
      string      tag;
   } exp_t;

   exp_t       exp_mosi[$];
   logic [7:0] exp_rd[$];
   logic [7:0] dev_rd[$];
   logic [7:0] wr_q[$];

   int         cfg_wait = 0;
   logic [7:0] cfg_hdr_last = 8'h00;
   bit         cfg_read = 1'b0;
   int         dphase = 0;
   int         dev_byte = 0;
   int         polls = 0;
   bit         mode_bad = 1'b0;
   bit         busy_bad = 1'b0;
   bit         seen_done = 1'b0;
   bit         seen_cs = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push_exp(input logic [7:0] v, input string tag);
      exp_t e;
      e.v   = v;
      e.tag = tag;
      exp_mosi.push_back(e);
   endtask

   function automatic logic [7:0] next_out();
      if (dphase == 0) return (dev_byte == 3) ? cfg_hdr_last : 8'h00;
      if (dphase == 1) return (polls < cfg_wait) ? 8'hFE : 8'h01;
      if (cfg_read && dev_rd.size() > 0) return dev_rd.pop_front();
      return 8'h00;
   endfunction

   // Scoreboard monitor for each completed bus byte.
   task automatic byte_seen(input logic [7:0] got, input logic [7:0] sent);
      if (exp_mosi.size() == 0) begin
         check(1'b0, "R4", "byte beyond frame", got, 0);
      end else begin
         exp_t e;
         e = exp_mosi.pop_front();
         check(got == e.v, e.tag, "MOSI byte", got, e.v);
      end
      if (dphase == 0 && dev_byte == 3) begin
         dphase = 1;
         polls  = 0;
      end else if (dphase == 1) begin
         if (sent[0]) dphase = 2;
         else         polls++;
      end
      dev_byte++;
   endtask

   // SPI device model: mode 0, shifts MISO on falling SCLK.
   initial begin : dev_model
      logic [7:0] shin;
      logic [7:0] cur_out;
      int         bitn;
      forever begin
         @(negedge cs_n);
         dphase   = 0;
         dev_byte = 0;
         polls    = 0;
         bitn     = 0;
         shin     = 8'h00;
         cur_out  = next_out();
         miso     = cur_out[7];
         forever begin
            @(posedge sclk or posedge cs_n);
            if (cs_n) break;
            shin = {shin[6:0], mosi};
            bitn++;
            @(negedge sclk or posedge cs_n);
            if (cs_n) break;
            if (bitn == 8) begin
               byte_seen(shin, cur_out);
               bitn    = 0;
               cur_out = next_out();
            end
            miso = cur_out[7-bitn];
         end
      end
   end

   // Write stream driver: pops a byte after each accepted handshake.
   initial begin : wr_driver
      bit take;
      take = 1'b0;
      forever begin
         @(negedge clk);
         if (take && wr_q.size() > 0) void'(wr_q.pop_front());
         wr_valid = (wr_q.size() > 0);
         wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
         take     = wr_valid && wr_ready;
      end
   end

   // Cycle monitor: read stream, release/done relation, busy, MOSI steadiness.
   initial begin : cyc_monitor
      logic prev_cs;
      logic prev_sclk;
      logic prev_mosi;
      prev_cs   = 1'b1;
      prev_sclk = 1'b0;
      prev_mosi = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (rd_valid) begin
               if (exp_rd.size() == 0) begin
                  check(1'b0, "R6", "unexpected read byte", rd_data, 0);
               end else begin
                  logic [7:0] ev;
                  ev = exp_rd.pop_front();
                  check(rd_data == ev, "R6", "read stream byte", rd_data, ev);
               end
            end
            if (done) seen_done = 1'b1;
            if (!cs_n) seen_cs = 1'b1;
            if (!cs_n && !busy) busy_bad = 1'b1;
            if (sclk && prev_sclk && mosi !== prev_mosi) mode_bad = 1'b1; // R10
            if (cs_n && !prev_cs) begin
               check(done == 1'b1, "R9", "done with release", done, 1);
               check(exp_mosi.size() == 0, "R4", "bytes missing at release", exp_mosi.size(), 0);
            end
         end
         prev_cs   = cs_n;
         prev_sclk = sclk;
         prev_mosi = mosi;
      end
   end

   task automatic run_txn(input bit rd, input int len, input logic [23:0] addr,
                          input int waitn, input int lim, input logic [7:0] hdr_last,
                          input bit expect_to);
      int npoll;
      cfg_read     = rd;
      cfg_wait     = waitn;
      cfg_hdr_last = hdr_last;
      mode_bad     = 1'b0;
      busy_bad     = 1'b0;
      push_exp({rd, 1'b1, 6'(len - 1)}, "R1");
      push_exp(addr[23:16], "R3");
      push_exp(addr[15:8], "R3");
      push_exp(addr[7:0], "R3");
      npoll = expect_to ? ((lim < 1) ? 1 : lim) : waitn + 1;
      for (int i = 0; i < npoll; i++) push_exp(8'h00, "R5");
      if (!expect_to) begin
         for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'(i * 53 + 165 + int'(addr[7:0]));
            if (rd) begin
               dev_rd.push_back(v);
               exp_rd.push_back(v);
               push_exp(8'h00, "R6");
            end else begin
               wr_q.push_back(v);
               push_exp(v, "R7");
            end
         end
      end
      @(negedge clk);
      start      = 1'b1;
      req_read   = rd;
      req_len    = LW'(len);
      req_addr   = addr;
      poll_limit = PW'(lim);
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9", "busy after start", busy, 1);
      do @(negedge clk); while (!done);
      check(err_timeout == expect_to, "R8", "timeout flag", err_timeout, expect_to);
      check(err_len == 1'b0, "R9", "length flag cleared", err_len, 0);
      check(!busy, "R9", "busy low after done", busy, 0);
      check(!busy_bad, "R9", "busy held through frame", busy_bad, 0);
      check(!mode_bad, "R10", "MOSI steady while SCLK high", mode_bad, 0);
      check(exp_rd.size() == 0, "R6", "read bytes outstanding", exp_rd.size(), 0);
      dev_rd.delete();
      wr_q.delete();
      repeat (3) @(negedge clk);
   endtask

   task automatic reject(input int len);
      seen_done = 1'b0;
      seen_cs   = 1'b0;
      @(negedge clk);
      start   = 1'b1;
      req_len = LW'(len);
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      check(err_len == 1'b1, "R2", "length flag", err_len, 1);
      check(!seen_cs, "R2", "chip select untouched", seen_cs, 0);
      check(!seen_done, "R2", "no done on refusal", seen_done, 0);
      check(sclk == 1'b0, "R2", "SCLK idle", sclk, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      check(cs_n == 1'b1, "R4", "reset cs_n", cs_n, 1);
      check(sclk == 1'b0, "R10", "reset sclk", sclk, 0);
      check(busy == 1'b0 && done == 1'b0, "R9", "reset busy/done", {busy, done}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_txn(1'b0, 4, 24'hD40018, 2, 10, 8'h00, 1'b0);   // R1 R3 R5 R7
      run_txn(1'b1, 4, 24'hD40F00, 0, 4, 8'hFF, 1'b0);    // R5: header byte bit 0 ignored
      run_txn(1'b1, 64, 24'hD40024, 3, 16, 8'h00, 1'b0);  // R1 R6 largest frame
      run_txn(1'b0, 1, 24'h000024, 1, 2, 8'h01, 1'b0);    // R7 single byte
      run_txn(1'b1, 2, 24'h123456, 1000, 3, 8'h00, 1'b1); // R8 timeout
      reject(0);                                          // R2
      reject(65);                                         // R2
      run_txn(1'b0, 3, 24'hABCDEF, 5, 6, 8'h00, 1'b0);    // R8 ready on the limit byte
      run_txn(1'b1, 2, 24'h00FF00, 5, 5, 8'h00, 1'b1);    // R8 one byte short
      run_txn(1'b1, 1, 24'h800001, 2, 0, 8'h00, 1'b1);    // R8 limit of zero

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule